// File: doc/BRIEF.md
# Macro ALU with Carry Chain

This block is the arithmetic and logic unit of a small macro processor's datapath. Each cycle it combines two 32-bit operands under a 5-bit operation code and returns a 32-bit result combinationally. A single registered carry flag persists between operations. The add and subtract forms update it, and the carry-in and borrow-in forms consume it, so a chain of instructions can build arithmetic wider than one word.

The operation code is the 5-bit field taken from instruction bits 21:17. The valid codes are:

- Arithmetic: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow.
- Logic: 8 exclusive-or, 9 or, 10 and, 11 and with inverted B, 12 inverted and.

Codes 4 to 7 and 13 to 31 are invalid. They are reported on a dedicated flag and produce no arithmetic effect.

The flag is written only on a clock edge where the commit enable is high. A synchronous reset clears it.

Top module: `seq_alu_carry`

## Requirements
- R1: With `op_code` = 0, `result` equals `op_a + op_b` modulo 2^32.
- R2: With `en` high and `op_code` 0 or 1, the flag after the clock edge equals the carry out of bit 31 of that sum.
- R3: With `op_code` = 1, `result` equals `op_a + op_b + carry` modulo 2^32.
- R4: With `op_code` = 2, `result` equals `op_a - op_b` modulo 2^32. With `en` high, the flag becomes 1 exactly when `op_a >= op_b` (unsigned).
- R5: With `op_code` = 3, `result` equals `op_a - op_b - (1 - carry)` modulo 2^32. With `en` high, the flag becomes 1 exactly when `op_a >= op_b + (1 - carry)` (unsigned, no wrap).
- R6: The logic codes produce the following results: 8 gives `op_a ^ op_b`, 9 gives `op_a | op_b`, 10 gives `op_a & op_b`, 11 gives `op_a & ~op_b`, and 12 gives `~(op_a & op_b)`.
- R7: The logic codes 8 to 12 leave the carry flag unchanged even when `en` is high.
- R8: An invalid code (4 to 7 or 13 to 31) drives `result` to zero and `invalid` high, and leaves the carry flag unchanged.
- R9: With `en` low, the carry flag holds its value. `result` is still computed from the current inputs and flag.
- R10: With `rst` high at a clock edge, the flag becomes 0 regardless of `en` and `op_code`. After reset the flag reads 0.
- R11: Every valid code (0 to 3, 8 to 12) drives `invalid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear of the carry flag, active high |
| en | input | 1 | Commit enable for the carry flag update |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | input | 5 | Operation code (instruction bits 21:17) |
| result | output | 32 | Combinational result |
| invalid | output | 1 | High when `op_code` is not a valid operation |
| carry | output | 1 | Registered carry / no-borrow flag |

## Verification
Addition is exercised with small operands, all-ones plus small values, and two top-bit-only operands. These separate a correct bit-31 carry from a truncated one and catch a carry-in that is ignored or inverted. Subtraction is applied with A above, below and equal to B, under both flag values. The equal case and the borrow-in case tell the no-borrow convention apart from a plain borrow flag. Logic codes use alternating and complementary bit patterns while the flag is set, so a swapped function or a flag disturbed by a logic code shows up. A sweep over every code, including the whole invalid range, with random operands and random enables, completes the check of decode holes, the enable gating and a reset asserted mid-chain.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

    localparam int OPW = 5;

    localparam logic [OPW-1:0] OP_ADD  = 5'd0;
    localparam logic [OPW-1:0] OP_ADC  = 5'd1;
    localparam logic [OPW-1:0] OP_SUB  = 5'd2;
    localparam logic [OPW-1:0] OP_SBB  = 5'd3;
    localparam logic [OPW-1:0] OP_XOR  = 5'd8;
    localparam logic [OPW-1:0] OP_OR   = 5'd9;
    localparam logic [OPW-1:0] OP_AND  = 5'd10;
    localparam logic [OPW-1:0] OP_ANDN = 5'd11;
    localparam logic [OPW-1:0] OP_NAND = 5'd12;

    typedef enum logic [2:0] {
        LG_XOR  = 3'd0,
        LG_OR   = 3'd1,
        LG_AND  = 3'd2,
        LG_ANDN = 3'd3,
        LG_NAND = 3'd4
    } logic_fn_e;

    // decoded control for one operation
    typedef struct packed {
        logic      arith;     // goes through the adder, may update the flag
        logic      logic_op;  // goes through the bitwise slice
        logic      sub;       // invert B in the adder
        logic      chain;     // adder carry-in comes from the flag
        logic_fn_e lfn;
    } op_dec_t;

    typedef struct packed {
        logic carry;
    } flag_st_t;

endpackage

// File: rtl/seq_alu_decode.sv
module seq_alu_decode
    import seq_alu_pkg::*;
(
    input  logic [OPW-1:0] code,
    output op_dec_t        dec
);

    always_comb begin
        dec = '{arith: 1'b0, logic_op: 1'b0, sub: 1'b0, chain: 1'b0, lfn: LG_XOR};
        case (code)
            OP_ADD:  dec.arith = 1'b1;
            OP_ADC:  begin dec.arith = 1'b1; dec.chain = 1'b1; end
            OP_SUB:  begin dec.arith = 1'b1; dec.sub = 1'b1; end
            OP_SBB:  begin dec.arith = 1'b1; dec.sub = 1'b1; dec.chain = 1'b1; end
            OP_XOR:  begin dec.logic_op = 1'b1; dec.lfn = LG_XOR;  end
            OP_OR:   begin dec.logic_op = 1'b1; dec.lfn = LG_OR;   end
            OP_AND:  begin dec.logic_op = 1'b1; dec.lfn = LG_AND;  end
            OP_ANDN: begin dec.logic_op = 1'b1; dec.lfn = LG_ANDN; end
            OP_NAND: begin dec.logic_op = 1'b1; dec.lfn = LG_NAND; end
            default: ;
        endcase
    end

endmodule

// File: rtl/seq_alu_adder.sv
// One adder serves all four arithmetic codes: subtraction is A + ~B + cin,
// where cin is 1 for plain subtract and the flag for the chained forms.
module seq_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         flag,
    input  logic         sub,
    input  logic         chain,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] b_eff;
    logic         cin;

    assign b_eff = sub ? ~b : b;
    assign cin   = chain ? flag : sub;
    assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};

endmodule

// File: rtl/seq_alu_bitwise.sv
module seq_alu_bitwise
    import seq_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = (fn == LG_XOR)  ? (a[i] ^ b[i])  :
                      (fn == LG_OR)   ? (a[i] | b[i])  :
                      (fn == LG_AND)  ? (a[i] & b[i])  :
                      (fn == LG_ANDN) ? (a[i] & ~b[i]) :
                                        ~(a[i] & b[i]);
    end

endmodule

// File: rtl/seq_alu_carry.sv
module seq_alu_carry
    import seq_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [OPW-1:0] op_code,
    output logic [W-1:0]   result,
    output logic           invalid,
    output logic           carry
);

    op_dec_t      dec;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] lg_out;
    flag_st_t     st_d, st_q;

    seq_alu_decode u_dec (
        .code (op_code),
        .dec  (dec)
    );

    seq_alu_adder #(.W(W)) u_add (
        .a     (op_a),
        .b     (op_b),
        .flag  (st_q.carry),
        .sub   (dec.sub),
        .chain (dec.chain),
        .sum   (add_sum),
        .cout  (add_cout)
    );

    seq_alu_bitwise #(.W(W)) u_lg (
        .a  (op_a),
        .b  (op_b),
        .fn (dec.lfn),
        .y  (lg_out)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.carry = 1'b0;
        end else if (en && dec.arith) begin
            st_d.carry = add_cout;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        if (dec.arith) begin
            result = add_sum;
        end else if (dec.logic_op) begin
            result = lg_out;
        end else begin
            result = '0;
        end
    end

    assign invalid = ~(dec.arith | dec.logic_op);
    assign carry   = st_q.carry;

endmodule

// File: rtl/seq_alu_carry_chk.sv
module seq_alu_carry_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [4:0]   op_code,
    input logic [W-1:0] result,
    input logic         invalid,
    input logic         carry
);

    logic [W:0] wide_add;
    logic       code_ok;

    assign wide_add = {1'b0, op_a} + {1'b0, op_b};
    assign code_ok  = (op_code <= 5'd3) || (op_code >= 5'd8 && op_code <= 5'd12);

    a_r2_add_carry: assert property (@(posedge clk) disable iff (rst)
        (en && op_code == 5'd0) |=> (carry == $past(wide_add[W])));

    a_r7_logic_keeps: assert property (@(posedge clk) disable iff (rst)
        (en && op_code >= 5'd8 && op_code <= 5'd12) |=> (carry == $past(carry)));

    a_r8_zero_result: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (result == '0));

    a_r8_flag_kept: assert property (@(posedge clk) disable iff (rst)
        invalid |=> (carry == $past(carry)));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> (carry == $past(carry)));

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (carry == 1'b0));

    a_r11_valid_clean: assert property (@(posedge clk) disable iff (rst)
        code_ok |-> !invalid);

endmodule

bind seq_alu_carry seq_alu_carry_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_code (op_code),
    .result  (result),
    .invalid (invalid),
    .carry   (carry)
);

// File: tb/seq_alu_carry_bench.sv
module seq_alu_carry_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [4:0]   code = '0;
    logic [W-1:0] result;
    logic         invalid;
    logic         carry;

    always #2 clk = ~clk;   // 250 MHz

    seq_alu_carry #(.W(W)) u_seq_alu_carry (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .op_a    (a),
        .op_b    (b),
        .op_code (code),
        .result  (result),
        .invalid (invalid),
        .carry   (carry)
    );

    typedef struct {
        logic [W-1:0] res;
        logic         inv;
        logic         c_pre;
        logic         c_post;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic mc = 1'b0;   // model flag
    bit   done = 0;

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0: return "R1";
            5'd1: return "R3";
            5'd2: return "R4";
            5'd3: return "R5";
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R6";
            default: return "R8";
        endcase
    endfunction

    // driver: drives one vector and pushes what the outputs must be
    task automatic apply(input logic r, input logic e, input logic [4:0] op,
                         input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        exp_t         it;
        logic [W:0]   wide;
        logic [W-1:0] rr;
        logic         co;
        logic         iv;
        @(negedge clk);
        rst = r; en = e; code = op; a = x; b = y;
        iv = 1'b0; co = mc; rr = '0;
        case (op)
            5'd0: begin wide = {1'b0, x} + {1'b0, y}; rr = wide[W-1:0]; co = wide[W]; end
            5'd1: begin wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, mc}; rr = wide[W-1:0]; co = wide[W]; end
            5'd2: begin rr = x - y; co = (x >= y); end
            5'd3: begin
                rr = x - y - {{(W-1){1'b0}}, ~mc};
                co = ({1'b0, x} >= ({1'b0, y} + {{W{1'b0}}, ~mc}));
            end
            5'd8:  rr = x ^ y;
            5'd9:  rr = x | y;
            5'd10: rr = x & y;
            5'd11: rr = x & ~y;
            5'd12: rr = ~(x & y);
            default: iv = 1'b1;
        endcase
        it.res = rr;
        it.inv = iv;
        it.c_pre = mc;
        if (r) mc = 1'b0;
        else if (e && op <= 5'd3) mc = co;
        it.c_post = mc;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: combinational outputs before the edge, flag after it
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.tag, "result", result, it.res);
                chk(it.tag, "invalid", {{(W-1){1'b0}}, invalid}, {{(W-1){1'b0}}, it.inv});
                chk(it.tag, "carry_before", {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, it.c_pre});
                @(posedge clk);
                #1;
                chk(it.tag, "carry_after", {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, it.c_post});
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R10: reset wins over an enabled carrying add; flag reads 0 after reset
        apply(1, 1, 5'd0, 32'hFFFF_FFFF, 32'h1, "R10");
        apply(0, 1, 5'd0, 32'd5, 32'd7, "R1");
        apply(0, 1, 5'd0, 32'hFFFF_FFFF, 32'd2, "R2");
        apply(0, 1, 5'd1, 32'd10, 32'd20, "R3");             // 31, flag 0
        apply(0, 1, 5'd0, 32'h8000_0000, 32'h8000_0000, "R2");
        // R7: logic codes with flag set leave it set
        apply(0, 1, 5'd8, 32'hAAAA_AAAA, 32'hFFFF_0000, "R7");
        apply(0, 1, 5'd9, 32'hAAAA_AAAA, 32'h5555_0000, "R6");
        apply(0, 1, 5'd10, 32'hAAAA_AAAA, 32'hF0F0_F0F0, "R6");
        apply(0, 1, 5'd11, 32'hAAAA_AAAA, 32'hF0F0_F0F0, "R6");
        apply(0, 1, 5'd12, 32'hAAAA_AAAA, 32'hF0F0_F0F0, "R6");
        apply(0, 1, 5'd1, 32'hFFFF_FFFF, 32'h0, "R3");        // flag 1 -> 0, flag 1
        apply(0, 1, 5'd2, 32'd9, 32'd4, "R4");
        apply(0, 1, 5'd2, 32'd4, 32'd9, "R4");
        apply(0, 1, 5'd2, 32'd7, 32'd7, "R4");
        apply(0, 1, 5'd3, 32'd10, 32'd3, "R5");               // flag 1: 7
        apply(0, 1, 5'd2, 32'd0, 32'd1, "R4");                // flag 0
        apply(0, 1, 5'd3, 32'd5, 32'd5, "R5");                // ffffffff, flag 0
        apply(0, 1, 5'd3, 32'd6, 32'd5, "R5");                // 0, flag 1
        apply(0, 1, 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
        apply(0, 1, 5'd7, 32'h1234_5678, 32'h1, "R8");
        apply(0, 1, 5'd13, 32'h1234_5678, 32'h1, "R8");
        apply(0, 1, 5'd31, 32'h1, 32'h1, "R8");
        apply(0, 1, 5'd10, 32'h0F0F_0F0F, 32'hFFFF_FFFF, "R11");
        apply(0, 1, 5'd2, 32'd0, 32'd1, "R4");                // flag 0
        apply(0, 0, 5'd0, 32'hFFFF_FFFF, 32'h1, "R9");        // carry out ignored
        apply(0, 1, 5'd0, 32'hFFFF_FFFF, 32'h1, "R2");        // flag 1
        apply(0, 0, 5'd2, 32'd1, 32'd2, "R9");                // would borrow, held
        apply(1, 0, 5'd1, 32'd1, 32'd1, "R10");               // mid-chain clear
        for (int i = 0; i < 400; i++) begin
            logic [4:0] op;
            op = 5'($urandom_range(0, 31));
            apply((i % 97) == 50, 1'($urandom_range(0, 3) != 0), op,
                  W'($urandom), (i % 5 == 0) ? W'($urandom_range(0, 3)) : W'($urandom), tag_of(op));
        end
        @(negedge clk);
        en = 1'b0;
        wait (sb.size() == 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule